// File: doc/BRIEF.md
# Raster Position Interrupt Generator

This block watches the horizontal and vertical beam positions of a video timing chain and turns them into processor interrupts. Two programmable 9-bit targets, one per axis, are compared against the incoming counters. A two-bit field in the control register picks the kind of match: none, horizontal only (once per line), vertical only (once per frame) or both together (once per frame, at one point on one line). A match sets a sticky interrupt flag that drives the interrupt line until software reads or writes the flag register.

Separately, the block detects the start of vertical blanking. It always sets a vertical-blank flag, and it emits a one-cycle non-maskable interrupt pulse only when that interrupt is enabled. Both the blanking start line (normal or overscan) and the last valid line (short or long region) are selected by input pins. A status register gives live vertical and horizontal blanking bits. The counters themselves come from outside.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset the control register is 0, `irq`, `nmi`, `nmi_flag` and `autopoll_en` are 0, and reading address 5 returns 0x02. Reset leaves both targets unchanged, and their power-on value is 0x1FF.
- R2: With control bits 5:4 = 00 no interrupt is raised, even when both counters equal their targets.
- R3: With bits 5:4 = 10 (vertical only), `irq` rises one cycle after `v_pos` first equals the vertical target, whatever `h_pos` is. It does not rise again while `v_pos` stays on that line.
- R4: With bits 5:4 = 01 (horizontal only), `irq` rises one cycle after `h_pos` equals the horizontal target, on every line.
- R5: With bits 5:4 = 11, `irq` rises only when `h_pos` equals the horizontal target on the line where `v_pos` equals the vertical target.
- R6: A horizontal target above 339 never fires. A vertical target above the last line never fires; the last line is 261 when `pal_sel`=0 and 311 when `pal_sel`=1.
- R7: The interrupt flag is bit 7 of address 6 and `irq` follows it. A read or a write of address 6 clears it one cycle later.
- R8: `nmi` pulses for one cycle, one cycle after the first clock with `h_pos`=0x16 on line 0xE1 (line 0xF0 when `overscan`=1), but only when control bit 7 is 1.
- R9: The vertical-blank flag (`nmi_flag`, bit 7 of address 5) is set by the same event whatever control bit 7 is. Reading address 5 or `v_pos`=0 clears it. Bits 3:0 of address 5 hold the version value 2.
- R10: Address 7 bit 7 is the vertical-blank state: set at the blanking start event, cleared when `v_pos`=0. Bit 6 is 1 one cycle after `h_pos` >= 0x121 or `h_pos` < 0x12.
- R11: Control is address 0: bit 7 NMI enable, bits 5:4 IRQ mode, bit 0 drives `autopoll_en`. Address 1/2 hold the horizontal target low byte and bit 8 (in data bit 0). Address 3/4 do the same for the vertical target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_pos | input | 9 | Horizontal beam position |
| v_pos | input | 9 | Vertical beam position |
| pal_sel | input | 1 | 1 selects the 312-line region, 0 the 262-line region |
| overscan | input | 1 | 1 moves the blanking start to line 0xF0 |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt line, high while the IRQ flag is set |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| nmi_flag | output | 1 | Vertical-blank flag |
| vblank | output | 1 | Vertical blanking state |
| hblank | output | 1 | Horizontal blanking state |
| autopoll_en | output | 1 | Control bit 0 |

## Verification
The assertions assume the counters stay within their ranges and that a compare position is held for at least one clock. They also assume `reg_rd` and `reg_wr` are never high in the same cycle. The stimulus changes the counters only at the falling clock edge and keeps every position inside the selected region. It moves to a different position before expecting a new match. The sweeps run every horizontal position of a line and every line of a frame once, so any spurious fire from an out-of-range target would be seen.

// File: rtl/raster_pkg.sv
// Package: shared constants and register addresses for the raster interrupt block.
// Assumes: counters are at least 9 bits wide.
package raster_pkg;
    localparam int H_LAST      = 339;   // last horizontal position
    localparam int V_LAST_SHORT = 261;  // last line, 262-line region
    localparam int V_LAST_LONG  = 311;  // last line, 312-line region
    localparam int VB_LINE     = 'hE1;  // blanking start line, normal
    localparam int VB_LINE_OS  = 'hF0;  // blanking start line, overscan
    localparam int VB_HPOS     = 'h16;  // horizontal position of blanking start
    localparam int HB_SET      = 'h121; // horizontal blank begins
    localparam int HB_CLR      = 'h12;  // horizontal blank ends

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_HLO  = 3'd1,
        A_HHI  = 3'd2,
        A_VLO  = 3'd3,
        A_VHI  = 3'd4,
        A_NMIF = 3'd5,
        A_IRQF = 3'd6,
        A_STAT = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/raster_regs.sv
// Module: raster_regs
// Holds the control byte and the two position targets, and decodes the
// flag-clearing accesses. Targets have no reset: they start at all ones and
// keep their value through reset. Assumes reg_rd and reg_wr are exclusive.
module raster_regs
    import raster_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic          nmi_en,
    output logic [1:0]    irq_mode,
    output logic          autopoll_en,
    output logic [CW-1:0] htime,
    output logic [CW-1:0] vtime,
    output logic          nmi_rd_clr,
    output logic          irq_clr
);
    localparam int HIW = CW - 8;

    logic [7:0]    ctrl_q;
    logic [CW-1:0] tgt [2];
    logic          unused_wdata;

    // Control byte register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (reg_wr && reg_addr == 3'(A_CTRL))
            ctrl_q <= reg_wdata;
    end

    // One target register per axis, written as a low byte and a high part.
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam logic [2:0] LO_ADDR = (a == 0) ? 3'(A_HLO) : 3'(A_VLO);
        localparam logic [2:0] HI_ADDR = (a == 0) ? 3'(A_HHI) : 3'(A_VHI);
        logic [CW-1:0] tgt_q = '1;

        // Target byte lanes; no reset so the value survives a reset.
        always_ff @(posedge clk) begin
            if (reg_wr && reg_addr == LO_ADDR)
                tgt_q[7:0] <= reg_wdata;
            if (reg_wr && reg_addr == HI_ADDR)
                tgt_q[CW-1:8] <= reg_wdata[HIW-1:0];
        end
        assign tgt[a] = tgt_q;
    end

    assign htime       = tgt[0];
    assign vtime       = tgt[1];
    assign nmi_en      = ctrl_q[7];
    assign irq_mode    = ctrl_q[5:4];
    assign autopoll_en = ctrl_q[0];
    assign nmi_rd_clr  = reg_rd && (reg_addr == 3'(A_NMIF));
    assign irq_clr     = (reg_rd || reg_wr) && (reg_addr == 3'(A_IRQF));
    assign unused_wdata = ^{ctrl_q[6], ctrl_q[3:1], reg_wdata};
endmodule

// File: rtl/raster_match.sv
// Module: raster_match
// Compares the beam counters with the targets according to the IRQ mode,
// turns the match into a single-cycle event and keeps the sticky IRQ flag.
// Assumes a target beyond the counter range must never match.
module raster_match
    import raster_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] h_pos,
    input  logic [CW-1:0] v_pos,
    input  logic          pal_sel,
    input  logic [1:0]    irq_mode,
    input  logic [CW-1:0] htime,
    input  logic [CW-1:0] vtime,
    input  logic          irq_clr,
    output logic          irq_flag
);
    logic [CW-1:0] v_last;
    logic          h_hit, v_hit, cond, cond_q, fire;

    assign v_last = pal_sel ? CW'(V_LAST_LONG) : CW'(V_LAST_SHORT);
    assign h_hit  = (htime <= CW'(H_LAST)) && (h_pos == htime);
    assign v_hit  = (vtime <= v_last) && (v_pos == vtime);

    // Select the match condition for the current mode.
    always_comb begin
        case (irq_mode)
            2'b01:   cond = h_hit;
            2'b10:   cond = v_hit;
            2'b11:   cond = h_hit && v_hit;
            default: cond = 1'b0;
        endcase
    end

    assign fire = cond && !cond_q;

    // Remember last cycle's condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // Sticky IRQ flag: set by an event, cleared by a flag access.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (fire)    irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    // R2
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b00 && !irq_flag) |=> !irq_flag);
    // R6
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b01 && htime > CW'(H_LAST) && !irq_flag) |=> !irq_flag);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cond) |=> !irq_flag);
endmodule

// File: rtl/raster_vblank.sv
// Module: raster_vblank
// Detects the start and end of vertical blanking, raises the NMI pulse and
// keeps the vertical-blank flag, and tracks horizontal blanking.
// Assumes v_pos returns to 0 at the start of each frame.
module raster_vblank
    import raster_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] h_pos,
    input  logic [CW-1:0] v_pos,
    input  logic          overscan,
    input  logic          nmi_en,
    input  logic          nmi_rd_clr,
    output logic          nmi,
    output logic          nmi_flag,
    output logic          vblank,
    output logic          hblank
);
    logic [CW-1:0] v_start;
    logic          vb_cond, vb_cond_q, vb_evt, vb_end;

    assign v_start = overscan ? CW'(VB_LINE_OS) : CW'(VB_LINE);
    assign vb_cond = (v_pos == v_start) && (h_pos == CW'(VB_HPOS));
    assign vb_evt  = vb_cond && !vb_cond_q;
    assign vb_end  = (v_pos == '0);

    // Blanking state, NMI pulse and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_cond_q <= 1'b0;
            nmi       <= 1'b0;
            vblank    <= 1'b0;
            nmi_flag  <= 1'b0;
            hblank    <= 1'b0;
        end else begin
            vb_cond_q <= vb_cond;
            nmi       <= vb_evt && nmi_en;
            if (vb_evt)      vblank <= 1'b1;
            else if (vb_end) vblank <= 1'b0;
            if (vb_evt)                     nmi_flag <= 1'b1;
            else if (vb_end || nmi_rd_clr)  nmi_flag <= 1'b0;
            hblank <= (h_pos >= CW'(HB_SET)) || (h_pos < CW'(HB_CLR));
        end
    end

    // R8
    nmi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_en |=> !nmi);
    // R9
    vb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_pos == '0) |=> (!vblank && !nmi_flag));
    // R10
    hb_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == CW'(VB_HPOS + 'h40)) |=> !hblank);
endmodule

// File: rtl/raster_irq_gen.sv
// Module: raster_irq_gen (top)
// Raster position interrupt generator: register file, position matcher and
// blanking tracker, plus the read multiplexer. Reads are combinational;
// read side effects take hold at the clock edge of the access.
module raster_irq_gen
    import raster_pkg::*;
#(
    parameter int         CW      = 9,
    parameter logic [3:0] VERSION = 4'h2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] h_pos,
    input  logic [CW-1:0] v_pos,
    input  logic          pal_sel,
    input  logic          overscan,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          nmi,
    output logic          nmi_flag,
    output logic          vblank,
    output logic          hblank,
    output logic          autopoll_en
);
    logic          nmi_en, nmi_rd_clr, irq_clr, irq_flag;
    logic [1:0]    irq_mode;
    logic [CW-1:0] htime, vtime;

    raster_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .nmi_en(nmi_en),
        .irq_mode(irq_mode), .autopoll_en(autopoll_en), .htime(htime),
        .vtime(vtime), .nmi_rd_clr(nmi_rd_clr), .irq_clr(irq_clr)
    );

    raster_match #(.CW(CW)) u_match (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .pal_sel(pal_sel), .irq_mode(irq_mode), .htime(htime),
        .vtime(vtime), .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    raster_vblank #(.CW(CW)) u_vblank (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .overscan(overscan), .nmi_en(nmi_en), .nmi_rd_clr(nmi_rd_clr),
        .nmi(nmi), .nmi_flag(nmi_flag), .vblank(vblank), .hblank(hblank)
    );

    assign irq = irq_flag;

    // Read multiplexer; write-only addresses return zero.
    always_comb begin
        case (reg_addr)
            3'(A_NMIF): reg_rdata = {nmi_flag, 3'b000, VERSION};
            3'(A_IRQF): reg_rdata = {irq_flag, 7'b0};
            3'(A_STAT): reg_rdata = {vblank, hblank, 6'b0};
            default:    reg_rdata = 8'h00;
        endcase
    end

    // R7
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'(A_IRQF) && irq_mode == 2'b00) |=> !irq);
endmodule

// File: tb/sim_raster_irq_gen.sv
`timescale 1ns/1ps
module sim_raster_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] h_pos = '0, v_pos = '0;
    logic       pal_sel = 1'b0, overscan = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, nmi, nmi_flag, vblank, hblank, autopoll_en;
    int         n_chk = 0, n_err = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    raster_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .pal_sel(pal_sel), .overscan(overscan), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .nmi(nmi), .nmi_flag(nmi_flag),
        .vblank(vblank), .hblank(hblank), .autopoll_en(autopoll_en)
    );

    typedef struct packed {
        logic [1:0] op;    // 0 write, 1 position, 2 read
        logic [2:0] addr;
        logic [7:0] data;  // write data or expected read data
        logic [8:0] h;
        logic [8:0] v;
        logic       irq;   // expected irq after the step
        logic [3:0] req;
    } vec_t;

    localparam vec_t VEC [0:27] = '{
        '{2'd0, 3'd6, 8'h00, 9'h000, 9'd0, 1'b0, 4'd7},  // R7 clear by write
        '{2'd0, 3'd1, 8'h20, 9'h000, 9'd0, 1'b0, 4'd11}, // R11 target layout
        '{2'd0, 3'd2, 8'h00, 9'h000, 9'd0, 1'b0, 4'd11},
        '{2'd0, 3'd3, 8'h05, 9'h000, 9'd0, 1'b0, 4'd11},
        '{2'd0, 3'd4, 8'h00, 9'h000, 9'd0, 1'b0, 4'd11},
        '{2'd0, 3'd0, 8'h10, 9'h000, 9'd0, 1'b0, 4'd4},  // R4 horizontal mode
        '{2'd1, 3'd0, 8'h00, 9'h01F, 9'd3, 1'b0, 4'd4},
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd3, 1'b1, 4'd4},
        '{2'd1, 3'd0, 8'h00, 9'h021, 9'd3, 1'b1, 4'd7},
        '{2'd2, 3'd6, 8'h80, 9'h000, 9'd0, 1'b0, 4'd7},  // R7 read clears
        '{2'd1, 3'd0, 8'h00, 9'h022, 9'd3, 1'b0, 4'd7},
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd4, 1'b1, 4'd4},  // next line again
        '{2'd0, 3'd6, 8'h00, 9'h000, 9'd0, 1'b0, 4'd7},
        '{2'd2, 3'd6, 8'h00, 9'h000, 9'd0, 1'b0, 4'd7},
        '{2'd0, 3'd0, 8'h20, 9'h000, 9'd0, 1'b0, 4'd3},  // R3 vertical mode
        '{2'd1, 3'd0, 8'h00, 9'h010, 9'd4, 1'b0, 4'd3},
        '{2'd1, 3'd0, 8'h00, 9'h000, 9'd5, 1'b1, 4'd3},
        '{2'd2, 3'd6, 8'h80, 9'h000, 9'd0, 1'b0, 4'd7},
        '{2'd1, 3'd0, 8'h00, 9'h001, 9'd5, 1'b0, 4'd3},  // no refire on line
        '{2'd0, 3'd0, 8'h30, 9'h000, 9'd0, 1'b0, 4'd5},  // R5 both
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd4, 1'b0, 4'd5},
        '{2'd1, 3'd0, 8'h00, 9'h01F, 9'd5, 1'b0, 4'd5},
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd5, 1'b1, 4'd5},
        '{2'd2, 3'd6, 8'h80, 9'h000, 9'd0, 1'b0, 4'd5},
        '{2'd0, 3'd0, 8'h00, 9'h000, 9'd0, 1'b0, 4'd2},  // R2 mode off
        '{2'd1, 3'd0, 8'h00, 9'h021, 9'd5, 1'b0, 4'd2},
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd5, 1'b0, 4'd2},
        '{2'd1, 3'd0, 8'h00, 9'h020, 9'd4, 1'b0, 4'd2}
    };

    task automatic check(input int req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic pos(input logic [8:0] h, input logic [8:0] v);
        @(negedge clk);
        h_pos = h; v_pos = v;
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check(1, irq, 0); check(1, nmi, 0); check(1, nmi_flag, 0);
        check(1, autopoll_en, 0);
        rd(3'd5, rv); check(1, rv, 8'h02);
        // R1 power-on targets are 0x1FF: horizontal mode never fires
        wr(3'd0, 8'h10);
        seen = 0;
        for (int h = 0; h <= 339; h++) begin
            pos(9'(h), 9'd10);
            seen = seen | int'(irq);
        end
        check(1, seen, 0);
        // R1 reset keeps a written target
        wr(3'd1, 8'h40); wr(3'd2, 8'h00);
        pos(9'h000, 9'd10);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        check(1, irq, 0);
        wr(3'd0, 8'h10);
        pos(9'h03F, 9'd10);
        pos(9'h040, 9'd10); check(1, irq, 1);
        pos(9'h000, 9'd0);

        // Vector table walk
        for (int i = 0; i < 28; i++) begin
            case (VEC[i].op)
                2'd0: wr(VEC[i].addr, VEC[i].data);
                2'd1: pos(VEC[i].h, VEC[i].v);
                default: begin
                    rd(VEC[i].addr, rv);
                    check(int'(VEC[i].req), rv, VEC[i].data);
                end
            endcase
            check(int'(VEC[i].req), irq, VEC[i].irq);
        end

        // R6 horizontal target 340 never fires
        wr(3'd1, 8'h54); wr(3'd2, 8'h01); wr(3'd0, 8'h10);
        seen = 0;
        for (int h = 0; h <= 339; h++) begin
            pos(9'(h), 9'd7);
            seen = seen | int'(irq);
        end
        check(6, seen, 0);
        // R6 vertical target 262: silent in short region, fires in long
        wr(3'd3, 8'h06); wr(3'd4, 8'h01); wr(3'd0, 8'h20);
        seen = 0;
        for (int v = 0; v <= 261; v++) begin
            pos(9'h000, 9'(v));
            seen = seen | int'(irq);
        end
        check(6, seen, 0);
        pal_sel = 1'b1;
        pos(9'h000, 9'd262); check(6, irq, 1);
        rd(3'd6, rv); check(6, rv, 8'h80);
        pal_sel = 1'b0;
        wr(3'd0, 8'h00);
        pos(9'h000, 9'd0);

        // R8 NMI at blanking start when enabled
        wr(3'd0, 8'h80);
        pos(9'h016, 9'hE0); check(8, nmi, 0); check(9, nmi_flag, 0);
        pos(9'h015, 9'hE1); check(9, nmi_flag, 0);
        pos(9'h016, 9'hE1); check(8, nmi, 1); check(9, nmi_flag, 1);
        check(10, vblank, 1);
        pos(9'h017, 9'hE1); check(8, nmi, 0);
        // R9 read clears flag, version in low bits
        rd(3'd5, rv); check(9, rv, 8'h82);
        rd(3'd5, rv); check(9, rv, 8'h02);
        // R9 flag set with enable off, cleared at line 0
        wr(3'd0, 8'h00);
        pos(9'h000, 9'd0); check(10, vblank, 0);
        pos(9'h016, 9'hE1); check(8, nmi, 0); check(9, nmi_flag, 1);
        pos(9'h020, 9'hE2); check(9, nmi_flag, 1);
        rd(3'd7, rv); check(10, rv[7], 1);
        pos(9'h000, 9'd0); check(9, nmi_flag, 0);
        rd(3'd7, rv); check(10, rv[7], 0);
        // R8 overscan moves the start line
        overscan = 1'b1; wr(3'd0, 8'h80);
        pos(9'h016, 9'hE1); check(8, nmi, 0); check(9, nmi_flag, 0);
        pos(9'h016, 9'hF0); check(8, nmi, 1); check(9, nmi_flag, 1);
        overscan = 1'b0;
        pos(9'h000, 9'd0);

        // R10 horizontal blank window
        pos(9'h120, 9'd5); rd(3'd7, rv); check(10, rv, 8'h00);
        pos(9'h121, 9'd5); rd(3'd7, rv); check(10, rv, 8'h40);
        pos(9'h011, 9'd6); rd(3'd7, rv); check(10, rv, 8'h40);
        pos(9'h012, 9'd6); rd(3'd7, rv); check(10, rv, 8'h00);

        // R11 control bit 0 drives autopoll_en
        wr(3'd0, 8'h81); check(11, autopoll_en, 1);
        wr(3'd0, 8'h00); check(11, autopoll_en, 0);

        finish_run();
    end
endmodule